// File: doc/BRIEF.md
# Strobe-Framed Serial PCM Port

This block carries one 8-bit PCM sample each way per frame over a three-wire serial link: a bit clock, an input data line and an output data line. A strobe input that is high for exactly eight bit-clock periods marks the timeslot. Incoming bits are captured on falling bit-clock edges and gathered into a byte. Outgoing bits are launched on rising edges. Outside the strobe the output driver is released, so other devices can share the line.

Both parallel sides are streams with valid/ready handshakes. The transmit stream offers a byte. The port takes it only when a slot opens, and `tx_ready` pulses for one clock at that moment. A producer keeps `tx_valid` and `tx_data` steady until it sees the handshake. If no byte is offered when the slot opens, or the transmit path is disabled, the port sends a configurable quiet code instead.

The receive stream holds each completed byte with `rx_valid` until `rx_ready` accepts it. A consumer that stalls across a frame loses the older byte: the newer one replaces it. The whole block runs on the system clock `clk` and detects bit-clock edges by sampling, so the bit clock must be well below the system clock. Only the direct-clock rate codes (the 512 kHz class and faster) are served.

Top module: `ssi_pcm_port`

## Requirements
- R1: After reset `dout_oe`, `tx_ready`, `rx_valid` and `frame_err` are all 0.
- R2: `dout_oe` is 0 whenever the strobe is low, and it is 1 for every bit of a slot while the rate code is supported.
- R3: The transmit byte goes out MSB first, one bit per rising bit-clock edge. Exactly one transmit handshake happens per slot, at the slot's first rising edge.
- R4: When `tx_path_en` is 0, or no byte is offered at slot start, the slot carries the quiet code (parameter `QUIET_CODE`, default FFh), MSB first.
- R5: Received bits are captured on falling bit-clock edges, MSB first. `rx_valid` rises one clock after the clock in which the eighth bit is captured, which is three system clocks after the eighth falling edge appears on `bclk`.
- R6: `rx_valid` and `rx_data` hold until `rx_ready` is high. A later completed byte replaces an unaccepted one.
- R7: When `rx_path_en` is 0, completed bytes are not presented (`rx_valid` stays 0).
- R8: A strobe that falls after 1 to 7 captured bits sets `frame_err`, and the partial byte is never presented. `frame_err` stays set until reset.
- R9: A strobe longer than eight bit periods sets `frame_err`. The first eight bits are still delivered as a byte.
- R10: With `rate_sel` below 2 (codes 0 and 1, the 128 kHz and 256 kHz rates), the port is idle. `dout_oe` stays 0, no transmit handshake occurs, and nothing is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock, sampled by `clk` |
| stb | input | 1 | Active-high slot strobe, changes with rising `bclk` |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for `dout` (0 = released/tri-state) |
| rate_sel | input | 3 | Bit-rate code; values 2..7 are the direct-clock rates |
| tx_path_en | input | 1 | Transmit audio path enabled |
| rx_path_en | input | 1 | Receive audio path enabled |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | One-clock pulse when the slot takes the byte |
| tx_data | input | 8 | Transmit sample |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer accepts the received byte |
| rx_data | output | 8 | Received sample |
| frame_err | output | 1 | Sticky strobe-length error |

## Verification
The bench goes after strobe lengths of five and nine bit periods. A design that miscounted the slot would either present a truncated byte or miss the sticky error flag. Stalling the receive consumer across two frames shows whether the newest byte replaces the old one; a design that kept the first byte or dropped both would deliver the wrong value. Slots with no transmit byte offered, with the transmit path disabled, and with an unsupported rate code expose a port that drove stale data, took a byte it should have left alone, or enabled its output. A timed probe around the eighth falling edge catches a receive valid that comes out a clock early or late.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  // Rate codes at or above the threshold run straight off the bit clock.
  function automatic logic is_direct_rate(input logic [7:0] code,
                                          input logic [7:0] threshold);
    return code >= threshold;
  endfunction

  // Fill bit shifted in behind the outgoing sample.
  localparam logic SHIFT_FILL = 1'b1;

endpackage

// File: rtl/ssi_line_sync.sv
module ssi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic stb,
  input  logic din,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic stb_q,
  output logic stb_drop,
  output logic din_q
);
  logic bclk_q, bclk_qq, stb_qq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      stb_q   <= 1'b0;
      stb_qq  <= 1'b0;
      din_q   <= 1'b0;
    end else begin
      bclk_q  <= bclk;
      bclk_qq <= bclk_q;
      stb_q   <= stb;
      stb_qq  <= stb_q;
      din_q   <= din;
    end
  end

  assign bclk_rise = bclk_q & ~bclk_qq;
  assign bclk_fall = ~bclk_q & bclk_qq;
  assign stb_drop  = stb_qq & ~stb_q;

endmodule

// File: rtl/ssi_tx_ser.sv
module ssi_tx_ser #(
  parameter int                 W     = 8,
  parameter logic [W-1:0]       QUIET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         bclk_rise,
  input  logic         stb_q,
  input  logic         path_en,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic         dout,
  output logic         dout_oe
);
  logic         active;
  logic [W-1:0] shreg;
  logic [W-1:0] load_word;
  logic         slot_open;

  assign slot_open = run & bclk_rise & stb_q & ~active;
  assign tx_ready  = slot_open & path_en;
  assign load_word = (tx_ready && tx_valid) ? tx_data : QUIET;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      shreg  <= '0;
      dout   <= 1'b0;
    end else if (!stb_q) begin
      active <= 1'b0;
    end else if (run && bclk_rise) begin
      if (!active) begin
        active <= 1'b1;
        dout   <= load_word[W-1];
        shreg  <= {load_word[W-2:0], ssi_pkg::SHIFT_FILL};
      end else begin
        dout   <= shreg[W-1];
        shreg  <= {shreg[W-2:0], ssi_pkg::SHIFT_FILL};
      end
    end
  end

  assign dout_oe = active & stb_q;

  AST_READY_OPENS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> active); // R3

  AST_OE_WITHIN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_q) |-> !dout_oe); // R2

endmodule

// File: rtl/ssi_rx_deser.sv
module ssi_rx_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         bclk_fall,
  input  logic         stb_q,
  input  logic         stb_drop,
  input  logic         din_q,
  input  logic         path_en,
  input  logic         rx_ready,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         frame_err
);
  localparam int             CW   = $clog2(W + 1);
  localparam logic [CW-1:0]  FULL = CW'(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;
  logic          byte_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (run && bclk_fall && stb_q) begin
        if (cnt < FULL) begin
          shreg <= {shreg[W-2:0], din_q};
          cnt   <= cnt + CW'(1);
          if (cnt == FULL - CW'(1)) byte_done <= 1'b1;
        end else begin
          frame_err <= 1'b1;
        end
      end
      if (stb_drop) begin
        if (cnt != '0 && cnt != FULL) frame_err <= 1'b1;
        cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (byte_done && path_en) begin
      rx_valid <= 1'b1;
      rx_data  <= shreg;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R8

  AST_DONE_AT_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> cnt == FULL); // R5

  AST_NO_DATA_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en && !rx_valid |=> !rx_valid); // R7

endmodule

// File: rtl/ssi_pcm_port.sv
module ssi_pcm_port #(
  parameter int                      SAMPLE_W      = 8,
  parameter int                      RATE_W        = 3,
  parameter int                      MIN_SYNC_RATE = 2,
  parameter logic [SAMPLE_W-1:0]     QUIET_CODE    = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                stb,
  input  logic                din,
  output logic                dout,
  output logic                dout_oe,
  input  logic [RATE_W-1:0]   rate_sel,
  input  logic                tx_path_en,
  input  logic                rx_path_en,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [SAMPLE_W-1:0] tx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                frame_err
);
  logic bclk_rise, bclk_fall, stb_q, stb_drop, din_q;
  logic run;

  assign run = ssi_pkg::is_direct_rate(8'(rate_sel), 8'(MIN_SYNC_RATE));

  ssi_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .stb       (stb),
    .din       (din),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .stb_q     (stb_q),
    .stb_drop  (stb_drop),
    .din_q     (din_q)
  );

  ssi_tx_ser #(.W(SAMPLE_W), .QUIET(QUIET_CODE)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .bclk_rise (bclk_rise),
    .stb_q     (stb_q),
    .path_en   (tx_path_en),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

  ssi_rx_deser #(.W(SAMPLE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .bclk_fall (bclk_fall),
    .stb_q     (stb_q),
    .stb_drop  (stb_drop),
    .din_q     (din_q),
    .path_en   (rx_path_en),
    .rx_ready  (rx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .frame_err (frame_err)
  );

  AST_IDLE_RATE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tx_ready); // R10

endmodule

// File: tb/ssi_pcm_port_tb_top.sv
`timescale 1ns/1ps
module ssi_pcm_port_tb_top;
  localparam logic [7:0] QUIET = 8'hFF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, bclk, stb, din, dout, dout_oe;
  logic [2:0] rate_sel;
  logic       tx_path_en, rx_path_en, tx_valid, tx_ready, rx_valid, rx_ready, frame_err;
  logic [7:0] tx_data, rx_data;

  ssi_pcm_port dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .stb(stb), .din(din),
    .dout(dout), .dout_oe(dout_oe), .rate_sel(rate_sel),
    .tx_path_en(tx_path_en), .rx_path_en(rx_path_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .frame_err(frame_err)
  );

  int n_run = 0, n_fail = 0, hs_cnt = 0;
  bit reported = 0;
  logic [7:0] exp_rx[$];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) if (rst_n && tx_valid && tx_ready) hs_cnt++;

  // Monitor: pops the scoreboard on each receive handshake.
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_rx.size() == 0) chk("R5", "unexpected rx byte", rx_data, 32'hDEAD);
      else chk("R5", "rx byte", rx_data, exp_rx.pop_front());
    end
  end

  // Driver: one strobe-framed slot, pushes expected results first.
  task automatic slot(input string req, input logic [7:0] rxb, input int nbits,
                      input bit offer, input logic [7:0] txb,
                      input bit push_rx, input bit probe_lat);
    logic [7:0] got;
    logic [7:0] tx_exp;
    bit oe_ok;
    bit run;
    int hs0;
    hs0 = hs_cnt;
    run = (rate_sel >= 3'd2);
    tx_exp = (offer && tx_path_en && run) ? txb : QUIET;
    if (push_rx) exp_rx.push_back(rxb);
    if (offer) begin tx_valid = 1'b1; tx_data = txb; end
    got = 8'h00;
    oe_ok = 1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bclk = 1'b1; stb = 1'b1; din = (i < 8) ? rxb[7-i] : 1'b0;
      wait_n(3);
      if (dout_oe !== run) oe_ok = 0;
      if (i < 8) got[7-i] = dout;
      if (i == 0) tx_valid = 1'b0;
      @(negedge clk);
      bclk = 1'b0;
      if (probe_lat && i == 7) begin
        wait_n(2);
        chk("R5", "rx_valid before latency", rx_valid, 0);
        wait_n(1);
        chk("R5", "rx_valid after latency", rx_valid, 1);
      end else begin
        wait_n(3);
      end
    end
    @(negedge clk);
    bclk = 1'b1; stb = 1'b0; din = 1'b0;
    wait_n(3);
    chk("R2", "oe after strobe", dout_oe, 0);
    @(negedge clk);
    bclk = 1'b0;
    wait_n(3);
    chk("R2", {req, " oe in slot"}, oe_ok, 1);
    if (run && nbits >= 8) chk({"R3 R4 ", req}, "tx byte", got, tx_exp);
    chk("R3", {req, " handshakes"}, hs_cnt - hs0, (offer && tx_path_en && run) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    rst_n = 0; bclk = 0; stb = 0; din = 0; rate_sel = 3'd2;
    tx_path_en = 1; rx_path_en = 1; tx_valid = 0; tx_data = 0; rx_ready = 1;
    wait_n(5);
    chk("R1", "dout_oe", dout_oe, 0);
    chk("R1", "tx_ready", tx_ready, 0);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "frame_err", frame_err, 0);
    rst_n = 1;
    wait_n(4);

    slot("R3", 8'hA5, 8, 1, 8'h3C, 1, 1);
    slot("R3", 8'h01, 8, 1, 8'h80, 1, 0);
    slot("R4 underrun", 8'h5A, 8, 0, 8'h00, 1, 0);

    tx_path_en = 0; rx_path_en = 0;
    slot("R4 R7 disabled", 8'hC3, 8, 1, 8'h55, 0, 0);
    chk("R7", "rx_valid with path off", rx_valid, 0);
    tx_valid = 0; tx_path_en = 1; rx_path_en = 1;

    rx_ready = 0;
    slot("R6 first", 8'h11, 8, 1, 8'h42, 0, 0);
    chk("R6", "held valid", rx_valid, 1);
    chk("R6", "held data", rx_data, 8'h11);
    slot("R6 second", 8'h22, 8, 1, 8'h24, 1, 0);
    chk("R6", "replaced data", rx_data, 8'h22);
    rx_ready = 1;
    wait_n(3);
    chk("R6", "valid after accept", rx_valid, 0);

    slot("R8 short", 8'hF0, 5, 0, 8'h00, 0, 0);
    chk("R8", "frame_err after short", frame_err, 1);
    chk("R8", "partial byte discarded", rx_valid, 0);
    slot("R8 after", 8'h96, 8, 1, 8'h69, 1, 0);
    chk("R8", "frame_err sticky", frame_err, 1);

    rst_n = 0; wait_n(3); rst_n = 1; wait_n(3);
    chk("R1", "frame_err cleared by reset", frame_err, 0);

    slot("R9 long", 8'h6C, 9, 1, 8'hB7, 1, 0);
    chk("R9", "frame_err after long", frame_err, 1);

    rate_sel = 3'd1;
    slot("R10 slow rate", 8'h77, 8, 1, 8'hAA, 0, 0);
    chk("R10", "rx_valid at slow rate", rx_valid, 0);
    tx_valid = 0; rate_sel = 3'd2;

    wait_n(10);
    chk("R5", "scoreboard drained", exp_rx.size(), 0);
    report();
    $finish;
  end

endmodule